// File: doc/BRIEF.md
# Dual-Issue Register Scoreboard Interlock

This block sits at the issue point of an in-order pipeline that can start up to two instructions per cycle. Each cycle it receives two decoded instruction slots, the older in slot 0 and the younger in slot 1. It answers with a grant per slot and a stall flag. Each slot describes up to `NSRC` source registers, each with the pipeline stage offset at which the operand is consumed. A slot also gives an optional destination with the stage offset at which its result appears, and the number of extra cycles the instruction occupies the issue stage beyond its first.

Readiness is tracked per register as a timed lock, not a busy bit. Every register carries a down-counter holding the number of cycles until its newest pending result becomes readable. A source passes when that remaining time does not exceed the stage offset at which the source is read. When several writers of one register are in flight, the counter keeps the latest expiry.

A small occupancy state machine enforces the pairing rules for multi-cycle instructions. Its states are ST_OPEN (normal issue), ST_HOLD (an intermediate cycle of a multi-cycle instruction) and ST_TAIL (the final cycle of a multi-cycle instruction). The transitions are:
- ST_OPEN to ST_TAIL when a multi-cycle instruction with one extra cycle is granted.
- ST_OPEN to ST_HOLD when one with more extra cycles is granted.
- ST_HOLD to ST_TAIL when two cycles remain.
- ST_TAIL back to ST_OPEN after one cycle.
- Any state to ST_OPEN on flush.

Top module: `dual_issue_interlock`

## Requirements
- R1: Slot 0 is granted only if every valid source register becomes readable no later than the current cycle plus that source's need offset. Otherwise it is not granted and `stall` is high. A source whose register is ready exactly at that cycle passes.
- R2: A granted instruction with a destination makes that register readable at its issue cycle plus the result offset plus the extra-cycle count. For example, an instruction issued at cycle t with result offset 5 and one extra cycle is readable from t+6.
- R3: When a register has several outstanding locks, it becomes readable only when the latest one expires. A later, shorter lock does not shorten an earlier, longer one.
- R4: A multi-cycle instruction (extra-cycle count k > 0) never issues with a partner in slot 1. After it is granted, no slot is granted for the next k-1 cycles. In its final cycle (k cycles after issue) only slot 0 may be granted, and only for a single-cycle instruction.
- R5: Two instructions whose valid destinations name the same register are never granted in the same cycle, even when their operand timing would allow it.
- R6: Slot 1 is granted only together with slot 0, only in ST_OPEN, and only when both slots hold single-cycle instructions.
- R7: Slot 1's sources are checked against slot 0's destination using slot 0's new lock as well as the existing locks.
- R8: A synchronous `flush` clears all register locks and returns the occupancy machine to ST_OPEN from the next cycle on.
- R9: After reset every register is free and the occupancy machine is in ST_OPEN, so independent instructions pair at once.
- R10: `stall` equals slot 0 valid and not granted. With slot 0 invalid, nothing is granted and `stall` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous clear of all locks and occupancy |
| s0_vld | input | 1 | Slot 0 holds an instruction |
| s0_src_idx | input | NSRC*IW | Slot 0 source register indices, source j at bits j*IW |
| s0_src_vld | input | NSRC | Slot 0 per-source valid |
| s0_src_need | input | NSRC*STG_W | Slot 0 stage offset at which each source is read |
| s0_dst_vld | input | 1 | Slot 0 writes a destination |
| s0_dst_idx | input | IW | Slot 0 destination register |
| s0_dst_stg | input | STG_W | Slot 0 result stage offset |
| s0_xcyc | input | CYC_W | Slot 0 extra issue cycles beyond the first |
| s1_vld | input | 1 | Slot 1 holds an instruction |
| s1_src_idx | input | NSRC*IW | Slot 1 source register indices |
| s1_src_vld | input | NSRC | Slot 1 per-source valid |
| s1_src_need | input | NSRC*STG_W | Slot 1 source need offsets |
| s1_dst_vld | input | 1 | Slot 1 writes a destination |
| s1_dst_idx | input | IW | Slot 1 destination register |
| s1_dst_stg | input | STG_W | Slot 1 result stage offset |
| s1_xcyc | input | CYC_W | Slot 1 extra issue cycles |
| grant0 | output | 1 | Slot 0 starts this cycle |
| grant1 | output | 1 | Slot 1 starts this cycle |
| stall | output | 1 | Slot 0 held back this cycle |

## Verification
The hardest situation to reach is a register held by two overlapping locks where the later writer has the shorter latency. The only evidence from the ports is a reader that would pass against the newer lock but must still stall against the older one. The stimulus issues a long-latency writer and then a short-latency writer of the same register on the next cycle. It then presents a reader one cycle before and exactly at the older lock's expiry. The same boundary approach, probing one cycle early and then exactly on time, is used for the multi-cycle final-cycle window and for the flush recovery.

// File: rtl/dii_pkg.sv
package dii_pkg;

    typedef enum logic [1:0] {
        ST_OPEN = 2'd0,
        ST_HOLD = 2'd1,
        ST_TAIL = 2'd2
    } occ_state_t;

endpackage

// File: rtl/dii_lock_table.sv
module dii_lock_table #(
    parameter int NREG = 16,
    parameter int IW   = 4,
    parameter int RW   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               wa_en,
    input  logic [IW-1:0]      wa_idx,
    input  logic [RW-1:0]      wa_rel,
    input  logic               wb_en,
    input  logic [IW-1:0]      wb_idx,
    input  logic [RW-1:0]      wb_rel,
    output logic [NREG*RW-1:0] rem_flat
);

    // One down-counter per register: cycles left until its newest result is readable.
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [RW-1:0] cnt_q;
        logic [RW-1:0] dec;
        logic [RW-1:0] cand_a;
        logic [RW-1:0] cand_b;
        logic [RW-1:0] cnt_d;

        always_comb begin
            dec    = (cnt_q == '0) ? '0 : cnt_q - RW'(1);
            cand_a = (wa_en && wa_idx == IW'(g) && wa_rel != '0) ? wa_rel - RW'(1) : '0;
            cand_b = (wb_en && wb_idx == IW'(g) && wb_rel != '0) ? wb_rel - RW'(1) : '0;
            cnt_d  = dec;
            if (cand_a > cnt_d) cnt_d = cand_a;
            if (cand_b > cnt_d) cnt_d = cand_b;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     cnt_q <= '0;
            else if (flush) cnt_q <= '0;
            else            cnt_q <= cnt_d;
        end

        assign rem_flat[g*RW +: RW] = cnt_q;
    end

endmodule

// File: rtl/dii_src_check.sv
module dii_src_check #(
    parameter int NREG  = 16,
    parameter int IW    = 4,
    parameter int NSRC  = 2,
    parameter int STG_W = 4,
    parameter int RW    = 5
) (
    input  logic [NREG*RW-1:0]    rem_flat,
    input  logic [NSRC*IW-1:0]    src_idx,
    input  logic [NSRC-1:0]       src_vld,
    input  logic [NSRC*STG_W-1:0] src_need,
    input  logic                  fw_en,
    input  logic [IW-1:0]         fw_idx,
    input  logic [RW-1:0]         fw_rel,
    output logic                  ok
);

    logic [RW-1:0] rem_arr [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_unpack
        assign rem_arr[g] = rem_flat[g*RW +: RW];
    end

    logic [IW-1:0] idx;
    logic [RW-1:0] eff;

    always_comb begin
        ok  = 1'b1;
        idx = '0;
        eff = '0;
        for (int j = 0; j < NSRC; j++) begin
            idx = src_idx[j*IW +: IW];
            eff = rem_arr[idx];
            // The older slot's new lock counts too, when it issues in the same cycle.
            if (fw_en && fw_idx == idx && fw_rel > eff) eff = fw_rel;
            if (src_vld[j] && eff > RW'(src_need[j*STG_W +: STG_W])) ok = 1'b0;
        end
    end

endmodule

// File: rtl/dii_occupancy.sv
module dii_occupancy
    import dii_pkg::*;
#(
    parameter int CYC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             start_multi,
    input  logic [CYC_W-1:0] start_xcyc,
    output logic             open_o,
    output logic             tail_o
);

    occ_state_t       state_q, state_d;
    logic [CYC_W-1:0] left_q, left_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OPEN;
            left_q  <= '0;
        end else if (flush) begin
            state_q <= ST_OPEN;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
        end
    end

    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        unique case (state_q)
            ST_OPEN: begin
                if (start_multi) begin
                    left_d  = start_xcyc;
                    state_d = (start_xcyc == CYC_W'(1)) ? ST_TAIL : ST_HOLD;
                end
            end
            ST_HOLD: begin
                left_d = left_q - CYC_W'(1);
                if (left_q == CYC_W'(2)) state_d = ST_TAIL;
            end
            ST_TAIL: begin
                left_d  = '0;
                state_d = ST_OPEN;
            end
            default: begin
                left_d  = '0;
                state_d = ST_OPEN;
            end
        endcase
    end

    always_comb begin
        open_o = (state_q == ST_OPEN);
        tail_o = (state_q == ST_TAIL);
    end

endmodule

// File: rtl/dual_issue_interlock.sv
module dual_issue_interlock #(
    parameter int NREG  = 16,
    parameter int NSRC  = 2,
    parameter int STG_W = 4,
    parameter int CYC_W = 3,
    localparam int IW     = $clog2(NREG),
    localparam int MAXREL = ((1 << STG_W) - 1) + ((1 << CYC_W) - 1),
    localparam int RW     = $clog2(MAXREL + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush,
    input  logic                  s0_vld,
    input  logic [NSRC*IW-1:0]    s0_src_idx,
    input  logic [NSRC-1:0]       s0_src_vld,
    input  logic [NSRC*STG_W-1:0] s0_src_need,
    input  logic                  s0_dst_vld,
    input  logic [IW-1:0]         s0_dst_idx,
    input  logic [STG_W-1:0]      s0_dst_stg,
    input  logic [CYC_W-1:0]      s0_xcyc,
    input  logic                  s1_vld,
    input  logic [NSRC*IW-1:0]    s1_src_idx,
    input  logic [NSRC-1:0]       s1_src_vld,
    input  logic [NSRC*STG_W-1:0] s1_src_need,
    input  logic                  s1_dst_vld,
    input  logic [IW-1:0]         s1_dst_idx,
    input  logic [STG_W-1:0]      s1_dst_stg,
    input  logic [CYC_W-1:0]      s1_xcyc,
    output logic                  grant0,
    output logic                  grant1,
    output logic                  stall
);

    logic [NREG*RW-1:0] rem_flat;
    logic [RW-1:0]      rel0, rel1;
    logic               st_open, st_tail;
    logic               s0_multi, s1_multi;

    assign rel0     = RW'(s0_dst_stg) + RW'(s0_xcyc);
    assign rel1     = RW'(s1_dst_stg) + RW'(s1_xcyc);
    assign s0_multi = (s0_xcyc != '0);
    assign s1_multi = (s1_xcyc != '0);

    // Per-slot source checks; only the younger slot sees the older slot's new lock.
    logic [NSRC*IW-1:0]    sl_idx  [2];
    logic [NSRC-1:0]       sl_sv   [2];
    logic [NSRC*STG_W-1:0] sl_need [2];
    logic                  sl_ok   [2];

    assign sl_idx[0]  = s0_src_idx;
    assign sl_idx[1]  = s1_src_idx;
    assign sl_sv[0]   = s0_src_vld;
    assign sl_sv[1]   = s1_src_vld;
    assign sl_need[0] = s0_src_need;
    assign sl_need[1] = s1_src_need;

    for (genvar s = 0; s < 2; s++) begin : g_slot
        dii_src_check #(
            .NREG (NREG),
            .IW   (IW),
            .NSRC (NSRC),
            .STG_W(STG_W),
            .RW   (RW)
        ) u_chk (
            .rem_flat(rem_flat),
            .src_idx (sl_idx[s]),
            .src_vld (sl_sv[s]),
            .src_need(sl_need[s]),
            .fw_en   ((s == 1) ? s0_dst_vld : 1'b0),
            .fw_idx  (s0_dst_idx),
            .fw_rel  (rel0),
            .ok      (sl_ok[s])
        );
    end

    logic same_dst;
    assign same_dst = s0_dst_vld && s1_dst_vld && (s0_dst_idx == s1_dst_idx);

    always_comb begin
        grant0 = s0_vld && sl_ok[0] && (st_open || (st_tail && !s0_multi));
        grant1 = grant0 && st_open && s1_vld && sl_ok[1]
                 && !s0_multi && !s1_multi && !same_dst;
        stall  = s0_vld && !grant0;
    end

    dii_lock_table #(
        .NREG(NREG),
        .IW  (IW),
        .RW  (RW)
    ) u_locks (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .wa_en   (grant0 && s0_dst_vld),
        .wa_idx  (s0_dst_idx),
        .wa_rel  (rel0),
        .wb_en   (grant1 && s1_dst_vld),
        .wb_idx  (s1_dst_idx),
        .wb_rel  (rel1),
        .rem_flat(rem_flat)
    );

    dii_occupancy #(
        .CYC_W(CYC_W)
    ) u_occ (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .start_multi(grant0 && s0_multi),
        .start_xcyc (s0_xcyc),
        .open_o     (st_open),
        .tail_o     (st_tail)
    );

endmodule

// File: rtl/dii_checker.sv
module dii_checker #(
    parameter int IW    = 4,
    parameter int NSRC  = 2,
    parameter int STG_W = 4,
    parameter int CYC_W = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  flush,
    input logic                  s0_vld,
    input logic [NSRC*IW-1:0]    s0_src_idx,
    input logic [NSRC-1:0]       s0_src_vld,
    input logic [NSRC*STG_W-1:0] s0_src_need,
    input logic                  s0_dst_vld,
    input logic [IW-1:0]         s0_dst_idx,
    input logic [STG_W-1:0]      s0_dst_stg,
    input logic [CYC_W-1:0]      s0_xcyc,
    input logic                  s1_dst_vld,
    input logic [IW-1:0]         s1_dst_idx,
    input logic                  grant0,
    input logic                  grant1,
    input logic                  stall
);

    AST_YOUNGER_NEEDS_OLDER: assert property (@(posedge clk) disable iff (!rst_n) grant1 |-> grant0); // R6

    AST_DST_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n) (grant1 && s0_dst_vld && s1_dst_vld) |-> (s0_dst_idx != s1_dst_idx)); // R5

    AST_MULTI_UNPAIRED: assert property (@(posedge clk) disable iff (!rst_n) (grant0 && s0_xcyc != '0) |-> !grant1); // R4

    AST_MULTI_HOLDS_NEXT: assert property (@(posedge clk) disable iff (!rst_n) (grant0 && s0_xcyc > CYC_W'(1) && !flush) |=> !grant0); // R4

    AST_NO_EARLY_READ: assert property (@(posedge clk) disable iff (!rst_n) (grant0 && s0_dst_vld && s0_xcyc == '0 && s0_dst_stg > STG_W'(1) && !flush) |=> !(grant0 && s0_src_vld[0] && s0_src_idx[IW-1:0] == $past(s0_dst_idx) && s0_src_need[STG_W-1:0] == '0)); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !s0_vld |-> (!grant0 && !stall)); // R10

endmodule

bind dual_issue_interlock dii_checker #(
    .IW   (IW),
    .NSRC (NSRC),
    .STG_W(STG_W),
    .CYC_W(CYC_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .s0_vld     (s0_vld),
    .s0_src_idx (s0_src_idx),
    .s0_src_vld (s0_src_vld),
    .s0_src_need(s0_src_need),
    .s0_dst_vld (s0_dst_vld),
    .s0_dst_idx (s0_dst_idx),
    .s0_dst_stg (s0_dst_stg),
    .s0_xcyc    (s0_xcyc),
    .s1_dst_vld (s1_dst_vld),
    .s1_dst_idx (s1_dst_idx),
    .grant0     (grant0),
    .grant1     (grant1),
    .stall      (stall)
);

// File: tb/sim_dual_issue_interlock.sv
`timescale 1ns/1ps
module sim_dual_issue_interlock;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;

    logic       s0_vld, s1_vld;
    logic [7:0] s0_src_idx, s1_src_idx;
    logic [1:0] s0_src_vld, s1_src_vld;
    logic [7:0] s0_src_need, s1_src_need;
    logic       s0_dst_vld, s1_dst_vld;
    logic [3:0] s0_dst_idx, s1_dst_idx;
    logic [3:0] s0_dst_stg, s1_dst_stg;
    logic [2:0] s0_xcyc, s1_xcyc;
    logic       grant0, grant1, stall;

    always #4 clk = ~clk;

    dual_issue_interlock u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .s0_vld(s0_vld), .s0_src_idx(s0_src_idx), .s0_src_vld(s0_src_vld),
        .s0_src_need(s0_src_need), .s0_dst_vld(s0_dst_vld), .s0_dst_idx(s0_dst_idx),
        .s0_dst_stg(s0_dst_stg), .s0_xcyc(s0_xcyc),
        .s1_vld(s1_vld), .s1_src_idx(s1_src_idx), .s1_src_vld(s1_src_vld),
        .s1_src_need(s1_src_need), .s1_dst_vld(s1_dst_vld), .s1_dst_idx(s1_dst_idx),
        .s1_dst_stg(s1_dst_stg), .s1_xcyc(s1_xcyc),
        .grant0(grant0), .grant1(grant1), .stall(stall)
    );

    typedef struct {
        logic  g0;
        logic  g1;
        logic  st;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_vec  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    // Slot set-up: sources a and b with valid and need, destination, extra cycles.
    task automatic sl(input int s, input logic v,
                      input logic [3:0] a, input logic av, input logic [3:0] an,
                      input logic [3:0] b, input logic bv, input logic [3:0] bn,
                      input logic dv, input logic [3:0] d, input logic [3:0] ds,
                      input logic [2:0] xc);
        if (s == 0) begin
            s0_vld = v; s0_src_idx = {b, a}; s0_src_vld = {bv, av}; s0_src_need = {bn, an};
            s0_dst_vld = dv; s0_dst_idx = d; s0_dst_stg = ds; s0_xcyc = xc;
        end else begin
            s1_vld = v; s1_src_idx = {b, a}; s1_src_vld = {bv, av}; s1_src_need = {bn, an};
            s1_dst_vld = dv; s1_dst_idx = d; s1_dst_stg = ds; s1_xcyc = xc;
        end
    endtask

    task automatic nop(input int s);
        sl(s, 1'b0, 4'd0, 1'b0, 4'd0, 4'd0, 1'b0, 4'd0, 1'b0, 4'd0, 4'd0, 3'd0);
    endtask

    // Independent single-cycle instruction reading r6, no destination.
    task automatic indep(input int s);
        sl(s, 1'b1, 4'd6, 1'b1, 4'd0, 4'd0, 1'b0, 4'd0, 1'b0, 4'd0, 4'd0, 3'd0);
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic expect3(input logic g0, input logic g1, input logic st, input string tag);
        exp_t e;
        e.g0 = g0; e.g1 = g1; e.st = st; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compares combinational grants mid-cycle, well before the next rising edge.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_vec++;
                if (grant0 !== e.g0 || grant1 !== e.g1 || stall !== e.st) begin
                    n_fail++;
                    $display("FAIL %s: got g0=%0b g1=%0b stall=%0b, expected g0=%0b g1=%0b stall=%0b",
                             e.tag, grant0, grant1, stall, e.g0, e.g1, e.st);
                end
            end
        end
    end

    initial begin
        #(8 * 5000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        nop(0); nop(1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        cyc(); nop(0); nop(1);                                   expect3(0, 0, 0, "R10 idle slot0");
        cyc(); sl(0, 1, 5, 1, 0, 0, 0, 0, 0, 0, 0, 0);
               sl(1, 1, 6, 1, 0, 0, 0, 0, 0, 0, 0, 0);           expect3(1, 1, 0, "R9 free after reset");
        // T0: two-cycle op, r0 readable from T0+6
        cyc(); sl(0, 1, 1, 1, 1, 2, 1, 2, 1, 0, 5, 1); nop(1);  expect3(1, 0, 0, "R2 multi issue");
        cyc(); sl(0, 1, 7, 1, 0, 0, 0, 0, 1, 8, 1, 0); indep(1); expect3(1, 0, 0, "R4 final-cycle pairing");
        cyc(); sl(0, 1, 0, 1, 3, 0, 0, 0, 0, 0, 0, 0); nop(1);  expect3(0, 0, 1, "R1 one cycle early");
        cyc();                                                   expect3(1, 0, 0, "R2 ready exactly on time");
        // R3: long lock then short lock on r3
        cyc(); sl(0, 1, 0, 0, 0, 0, 0, 0, 1, 3, 6, 0);          expect3(1, 0, 0, "R3 long writer");
        cyc(); sl(0, 1, 0, 0, 0, 0, 0, 0, 1, 3, 1, 0);          expect3(1, 0, 0, "R3 short writer");
        cyc(); sl(0, 1, 3, 1, 3, 0, 0, 0, 0, 0, 0, 0);          expect3(0, 0, 1, "R3 latest lock holds");
        cyc();                                                   expect3(1, 0, 0, "R3 latest lock expires");
        // R5: same destination pair
        cyc(); sl(0, 1, 0, 0, 0, 0, 0, 0, 1, 4, 1, 0);
               sl(1, 1, 4, 1, 2, 0, 0, 0, 1, 4, 1, 0);           expect3(1, 0, 0, "R5 shared destination");
        // R7: slot1 against slot0 new lock
        cyc(); sl(0, 1, 0, 0, 0, 0, 0, 0, 1, 9, 3, 0);
               sl(1, 1, 9, 1, 2, 0, 0, 0, 0, 0, 0, 0);           expect3(1, 0, 0, "R7 intra-pair too early");
        cyc(); sl(0, 1, 0, 0, 0, 0, 0, 0, 1, 10, 2, 0);
               sl(1, 1, 10, 1, 2, 0, 0, 0, 1, 11, 1, 0);         expect3(1, 1, 0, "R7 intra-pair in time");
        // R6: ordering and single-cycle pairing
        cyc(); nop(0); indep(1);                                 expect3(0, 0, 0, "R6 slot1 alone");
        cyc(); indep(0); sl(1, 1, 6, 1, 0, 0, 0, 0, 0, 0, 0, 1); expect3(1, 0, 0, "R6 multi in slot1");
        // R4: three extra cycles
        cyc(); sl(0, 1, 0, 0, 0, 0, 0, 0, 1, 12, 1, 3); indep(1); expect3(1, 0, 0, "R4 multi alone");
        cyc(); indep(0);                                         expect3(0, 0, 1, "R4 hold cycle 1");
        cyc();                                                   expect3(0, 0, 1, "R4 hold cycle 2");
        cyc();                                                   expect3(1, 0, 0, "R4 final cycle");
        cyc(); sl(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1); nop(1);  expect3(1, 0, 0, "R4 short multi");
        cyc();                                                   expect3(0, 0, 1, "R4 no multi in final");
        cyc();                                                   expect3(1, 0, 0, "R4 multi after final");
        cyc(); nop(0);                                           expect3(0, 0, 0, "R10 idle in final");
        // R8: flush clears locks
        cyc(); sl(0, 1, 0, 0, 0, 0, 0, 0, 1, 13, 15, 0);        expect3(1, 0, 0, "R8 long lock");
        cyc(); sl(0, 1, 13, 1, 0, 0, 0, 0, 0, 0, 0, 0);         expect3(0, 0, 1, "R1 locked reader");
        cyc(); flush = 1'b1; nop(0);                             expect3(0, 0, 0, "R8 flush cycle");
        cyc(); flush = 1'b0; sl(0, 1, 13, 1, 0, 0, 0, 0, 0, 0, 0, 0); expect3(1, 0, 0, "R8 locks cleared");
        cyc(); sl(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3);          expect3(1, 0, 0, "R8 multi before flush");
        cyc(); flush = 1'b1; nop(0);                             expect3(0, 0, 0, "R8 flush in hold");
        cyc(); flush = 1'b0; indep(0);                           expect3(1, 0, 0, "R8 occupancy cleared");
        cyc(); nop(0); nop(1);

        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule